// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Steering

This block decides, for each received CAN frame, whether the frame is kept and which of two receive buffers gets it. A frame is offered for one cycle with its identifier, its type (standard or extended) and its first two data bytes. One cycle later the block reports whether the frame was accepted, the buffer chosen, the index of the filter that matched, and a one-cycle overflow pulse when a matching frame had to be dropped because its buffer was full.

There are six filters in two groups. Buffer 0 owns filters 0 and 1, which share mask 0. Buffer 1 owns filters 2 to 5, which share mask 1. Filters and masks use one 29-bit key layout. For an extended frame the key is the 29-bit identifier. For a standard frame the key is built as follows:

- bits 28:18 carry the 11-bit identifier;
- bits 15:8 carry data byte 0;
- bits 7:0 carry data byte 1;
- bits 17:16 take no part in the compare.

Each buffer can be switched to receive-all, which accepts every frame for that buffer. When rollover is on, a frame meant for a full buffer 0 goes to buffer 1 instead.

Top module: `can_acf_top`

## Requirements
- R1: After reset, and until the first frame is offered, `done_o`, `accept_o`, `buf_sel_o`, `ovf0_o` and `ovf1_o` are 0 and `hit_o` is 0.
- R2: A frame offered with `frm_valid_i`=1 at a clock edge gives `done_o`=1 for exactly the following cycle. Without a valid frame, `done_o`, `accept_o`, `ovf0_o` and `ovf1_o` stay 0.
- R3: For an extended frame (`frm_ext_i`=1), filter n matches when ((id XOR filter) AND mask) is zero over all 29 bits and the filter's type bit `filt_ext_i[n]` is 1.
- R4: For a standard frame (`frm_ext_i`=0, identifier in `frm_id_i[10:0]`), the key is {SID, 2'b00, data0, data1}. Mask bits 17:16 are treated as 0, and a filter matches only if its type bit is 0.
- R5: The buffer 0 group (filters 0–1 under mask 0) is checked before the buffer 1 group (filters 2–5 under mask 1). Within a group, the lowest-numbered matching filter is reported on `hit_o` as its index 0–5. This happens whether or not the frame is stored.
- R6: When `rxall0_i` or `rxall1_i` is set, that buffer's group matches every frame, and `hit_o` reports the code 6.
- R7: When buffer 0 is wanted but `buf0_full_i`=1 and `rollover_i`=1, the frame is accepted into buffer 1 (`buf_sel_o`=1) if `buf1_full_i`=0. `buf1_full_i` has no effect on frames stored in buffer 0.
- R8: A frame wanted by a full buffer is dropped (`accept_o`=0). `ovf0_o` pulses when buffer 0 was full and rollover was off. `ovf1_o` pulses when the frame targeted buffer 1, either directly or through rollover, and buffer 1 was full. At most one overflow pulses, and never together with an accept.
- R9: A frame that no filter matches and no receive-all covers is rejected with `accept_o`=0, no overflow, and `hit_o`=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | Frame offered this cycle |
| frm_id_i | input | 29 | Identifier (standard: bits 10:0) |
| frm_ext_i | input | 1 | 1 = extended frame |
| frm_d0_i | input | 8 | Data byte 0 |
| frm_d1_i | input | 8 | Data byte 1 |
| mask0_i | input | 29 | Mask for filters 0–1 |
| mask1_i | input | 29 | Mask for filters 2–5 |
| filt_id_i | input | 174 | Filter keys, filter n at bits 29n+28:29n |
| filt_ext_i | input | 6 | Filter type bits, 1 = extended |
| rxall0_i | input | 1 | Buffer 0 receives all frames |
| rxall1_i | input | 1 | Buffer 1 receives all frames |
| rollover_i | input | 1 | Full buffer 0 spills into buffer 1 |
| buf0_full_i | input | 1 | Buffer 0 holds an unread frame |
| buf1_full_i | input | 1 | Buffer 1 holds an unread frame |
| done_o | output | 1 | Decision valid this cycle |
| accept_o | output | 1 | Frame is stored |
| buf_sel_o | output | 1 | Target buffer when accepted |
| hit_o | output | 3 | Matching filter index, 6 = none or receive-all |
| ovf0_o | output | 1 | Drop pulse for buffer 0 |
| ovf1_o | output | 1 | Drop pulse for buffer 1 |

## Verification
The assertions assume that the buffer-full flags, the rollover and receive-all controls, and the filter configuration are steady across the edge where a frame is offered. The `$past` checks on the full flags depend on this, since they relate a decision to the flags of the cycle before. The stimulus changes configuration and full flags only on falling edges, while no frame is being offered. Each frame is driven for a single cycle and followed by an idle cycle, so every decision is seen in isolation.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

  localparam int unsigned KEY_W = 29;
  localparam int unsigned SID_W = 11;

  typedef logic [KEY_W-1:0] key_t;

  typedef struct packed {
    logic accept;
    logic buf_sel;
    logic ovf0;
    logic ovf1;
  } route_t;

  // Build the compare key for a frame.
  function automatic key_t form_key(input key_t id, input logic ext,
                                    input logic [7:0] d0, input logic [7:0] d1);
    key_t k;
    if (ext) k = id;
    else     k = {id[SID_W-1:0], 2'b00, d0, d1};
    return k;
  endfunction

  // Bits 17:16 never take part in a standard-frame compare.
  function automatic key_t eff_mask(input key_t mask, input logic ext);
    key_t m;
    m = mask;
    if (!ext) m[17:16] = 2'b00;
    return m;
  endfunction

  function automatic logic filt_hit(input key_t key, input key_t fkey,
                                    input logic fext, input key_t mask,
                                    input logic ext);
    return (((key ^ fkey) & mask) == '0) && (fext == ext);
  endfunction

endpackage

// File: rtl/can_acf_bank.sv
module can_acf_bank
  import can_acf_pkg::*;
#(
  parameter int unsigned NF = 2
) (
  input  key_t                 key_i,
  input  logic                 ext_i,
  input  key_t                 mask_i,
  input  logic [NF*KEY_W-1:0]  fkey_i,
  input  logic [NF-1:0]        fext_i,
  output logic [NF-1:0]        hit_o
);
  key_t m_eff;
  assign m_eff = eff_mask(mask_i, ext_i);

  for (genvar g = 0; g < NF; g++) begin : g_flt
    assign hit_o[g] = filt_hit(key_i, fkey_i[g*KEY_W +: KEY_W], fext_i[g],
                               m_eff, ext_i);
  end
endmodule

// File: rtl/can_acf_prio.sv
module can_acf_prio #(
  parameter int unsigned N    = 4,
  parameter int unsigned IW   = 3,
  parameter int unsigned BASE = 0
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(BASE + i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/can_acf_steer.sv
module can_acf_steer
  import can_acf_pkg::*;
#(
  parameter int unsigned IW   = 3,
  parameter int unsigned NONE = 6
) (
  input  logic          any0_i,
  input  logic [IW-1:0] idx0_i,
  input  logic          any1_i,
  input  logic [IW-1:0] idx1_i,
  input  logic          rxall0_i,
  input  logic          rxall1_i,
  input  logic          rollover_i,
  input  logic          full0_i,
  input  logic          full1_i,
  output route_t        route_o,
  output logic [IW-1:0] hit_o
);
  logic want0, want1;
  assign want0 = rxall0_i | any0_i;
  assign want1 = rxall1_i | any1_i;

  always_comb begin
    route_o = '0;
    hit_o   = IW'(NONE);
    if (want0) begin
      hit_o = rxall0_i ? IW'(NONE) : idx0_i;
      if (!full0_i) begin
        route_o.accept = 1'b1;
      end else if (rollover_i) begin
        if (!full1_i) begin
          route_o.accept  = 1'b1;
          route_o.buf_sel = 1'b1;
        end else begin
          route_o.ovf1 = 1'b1;
        end
      end else begin
        route_o.ovf0 = 1'b1;
      end
    end else if (want1) begin
      hit_o = rxall1_i ? IW'(NONE) : idx1_i;
      if (!full1_i) begin
        route_o.accept  = 1'b1;
        route_o.buf_sel = 1'b1;
      end else begin
        route_o.ovf1 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_acf_top.sv
module can_acf_top
  import can_acf_pkg::*;
#(
  parameter int unsigned NF0 = 2,
  parameter int unsigned NF1 = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frm_valid_i,
  input  logic [28:0]                 frm_id_i,
  input  logic                        frm_ext_i,
  input  logic [7:0]                  frm_d0_i,
  input  logic [7:0]                  frm_d1_i,
  input  logic [28:0]                 mask0_i,
  input  logic [28:0]                 mask1_i,
  input  logic [(NF0+NF1)*29-1:0]     filt_id_i,
  input  logic [NF0+NF1-1:0]          filt_ext_i,
  input  logic                        rxall0_i,
  input  logic                        rxall1_i,
  input  logic                        rollover_i,
  input  logic                        buf0_full_i,
  input  logic                        buf1_full_i,
  output logic                        done_o,
  output logic                        accept_o,
  output logic                        buf_sel_o,
  output logic [$clog2(NF0+NF1+1)-1:0] hit_o,
  output logic                        ovf0_o,
  output logic                        ovf1_o
);
  localparam int unsigned NF   = NF0 + NF1;
  localparam int unsigned HW   = $clog2(NF + 1);
  localparam int unsigned NONE = NF;

  key_t             key;
  logic [NF0-1:0]   hv0;
  logic [NF1-1:0]   hv1;
  logic             any0, any1;
  logic [HW-1:0]    idx0, idx1, hit_d;
  route_t           route_d;

  assign key = form_key(frm_id_i, frm_ext_i, frm_d0_i, frm_d1_i);

  can_acf_bank #(.NF(NF0)) u_bank0 (
    .key_i(key), .ext_i(frm_ext_i), .mask_i(mask0_i),
    .fkey_i(filt_id_i[NF0*KEY_W-1:0]), .fext_i(filt_ext_i[NF0-1:0]),
    .hit_o(hv0)
  );

  can_acf_bank #(.NF(NF1)) u_bank1 (
    .key_i(key), .ext_i(frm_ext_i), .mask_i(mask1_i),
    .fkey_i(filt_id_i[NF*KEY_W-1:NF0*KEY_W]), .fext_i(filt_ext_i[NF-1:NF0]),
    .hit_o(hv1)
  );

  can_acf_prio #(.N(NF0), .IW(HW), .BASE(0)) u_prio0 (
    .vec_i(hv0), .any_o(any0), .idx_o(idx0)
  );

  can_acf_prio #(.N(NF1), .IW(HW), .BASE(NF0)) u_prio1 (
    .vec_i(hv1), .any_o(any1), .idx_o(idx1)
  );

  can_acf_steer #(.IW(HW), .NONE(NONE)) u_steer (
    .any0_i(any0), .idx0_i(idx0), .any1_i(any1), .idx1_i(idx1),
    .rxall0_i(rxall0_i), .rxall1_i(rxall1_i), .rollover_i(rollover_i),
    .full0_i(buf0_full_i), .full1_i(buf1_full_i),
    .route_o(route_d), .hit_o(hit_d)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      accept_o  <= 1'b0;
      buf_sel_o <= 1'b0;
      hit_o     <= '0;
      ovf0_o    <= 1'b0;
      ovf1_o    <= 1'b0;
    end else begin
      done_o    <= frm_valid_i;
      accept_o  <= frm_valid_i & route_d.accept;
      buf_sel_o <= frm_valid_i & route_d.buf_sel;
      hit_o     <= frm_valid_i ? hit_d : '0;
      ovf0_o    <= frm_valid_i & route_d.ovf0;
      ovf1_o    <= frm_valid_i & route_d.ovf1;
    end
  end

  // R2
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> done_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(accept_o || ovf0_o || ovf1_o));
  // R8
  single_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf0_o, ovf1_o, accept_o}));
  // R7
  buf0_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !buf_sel_o) |-> $past(!buf0_full_i));
  // R7
  buf1_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && buf_sel_o) |-> $past(!buf1_full_i));
  // R8
  ovf0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf0_o |-> $past(buf0_full_i && !rollover_i));
  // R8
  ovf1_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf1_o |-> $past(buf1_full_i));
endmodule

// File: tb/tb_can_acf_top.sv
`timescale 1ns/1ps
module tb_can_acf_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, frm_valid, frm_ext, rxall0, rxall1, rollover, full0, full1;
  logic [28:0] frm_id, mask0, mask1;
  logic [7:0]  d0, d1;
  logic [28:0] fid [6];
  logic [5:0]  fext;
  logic        done, acc, bsel, o0, o1;
  logic [2:0]  hit;

  int n_chk = 0;
  int n_fail = 0;

  can_acf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(frm_valid), .frm_id_i(frm_id),
    .frm_ext_i(frm_ext), .frm_d0_i(d0), .frm_d1_i(d1),
    .mask0_i(mask0), .mask1_i(mask1),
    .filt_id_i({fid[5], fid[4], fid[3], fid[2], fid[1], fid[0]}),
    .filt_ext_i(fext), .rxall0_i(rxall0), .rxall1_i(rxall1),
    .rollover_i(rollover), .buf0_full_i(full0), .buf1_full_i(full1),
    .done_o(done), .accept_o(acc), .buf_sel_o(bsel), .hit_o(hit),
    .ovf0_o(o0), .ovf1_o(o1)
  );

  // Result vector: {done, accept, buf, hit[2:0], ovf0, ovf1}
  task automatic check(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {done, acc, bsel, hit, o0, o1};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [28:0] id, input logic ext,
                      input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    frm_id = id; frm_ext = ext; d0 = b0; d1 = b1; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset state", 8'b0);
    @(negedge clk);
    check("R2 idle, no frame", 8'b0);
  endtask

  task automatic t_ext_match;
    send(29'h1234567, 1'b1, 8'h00, 8'h00);
    check("R3 ext exact -> buf0 f0", {3'b110, 3'd0, 2'b00});
    @(negedge clk);
    check("R2 one-cycle done", 8'b0);
  endtask

  task automatic t_ext_miss;
    send(29'h1234566, 1'b1, 8'h00, 8'h00);
    check("R9 ext miss rejected", {3'b100, 3'd6, 2'b00});
  endtask

  task automatic t_std_data;
    send(29'h123, 1'b0, 8'hAA, 8'h55);
    check("R4 std + data, bits17:16 ignored -> f1", {3'b110, 3'd1, 2'b00});
    send(29'h123, 1'b0, 8'hAB, 8'h55);
    check("R4 std data0 mismatch rejected", {3'b100, 3'd6, 2'b00});
  endtask

  task automatic t_buf1_prio;
    send(29'h456, 1'b0, 8'h12, 8'h34);
    check("R5 lowest of f2/f4 -> buf1 f2", {3'b111, 3'd2, 2'b00});
    send(29'h11580000, 1'b1, 8'h00, 8'h00);
    check("R3 ext vs std filter type mismatch", {3'b100, 3'd6, 2'b00});
    send(29'h0AB0000, 1'b1, 8'h00, 8'h00);
    check("R3 ext under mask1 -> f3", {3'b111, 3'd3, 2'b00});
  endtask

  task automatic t_rollover;
    @(negedge clk); full0 = 1'b1; rollover = 1'b1;
    send(29'h1234567, 1'b1, 8'h00, 8'h00);
    check("R7 rollover into buf1", {3'b111, 3'd0, 2'b00});
    @(negedge clk); full1 = 1'b1;
    send(29'h1234567, 1'b1, 8'h00, 8'h00);
    check("R8 rollover both full -> ovf1", {3'b100, 3'd0, 2'b01});
    @(negedge clk); rollover = 1'b0; full1 = 1'b0;
    send(29'h1234567, 1'b1, 8'h00, 8'h00);
    check("R8 buf0 full, no rollover -> ovf0", {3'b100, 3'd0, 2'b10});
    @(negedge clk); full0 = 1'b0; full1 = 1'b1;
    send(29'h456, 1'b0, 8'h00, 8'h00);
    check("R8 buf1 full -> ovf1", {3'b100, 3'd2, 2'b01});
    send(29'h1234567, 1'b1, 8'h00, 8'h00);
    check("R7 buf1 full irrelevant for buf0", {3'b110, 3'd0, 2'b00});
    @(negedge clk); full1 = 1'b0;
  endtask

  task automatic t_rxall;
    @(negedge clk); rxall1 = 1'b1;
    send(29'h1234566, 1'b1, 8'h00, 8'h00);
    check("R6 rxall1 accepts unmatched", {3'b111, 3'd6, 2'b00});
    @(negedge clk); rxall0 = 1'b1;
    send(29'h456, 1'b0, 8'h00, 8'h00);
    check("R6 R5 rxall0 precedence -> buf0", {3'b110, 3'd6, 2'b00});
    @(negedge clk); rxall0 = 1'b0; rxall1 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_id = '0; frm_ext = 1'b0; d0 = '0; d1 = '0;
    rxall0 = 1'b0; rxall1 = 1'b0; rollover = 1'b0; full0 = 1'b0; full1 = 1'b0;
    mask0 = 29'h1FFFFFFF;
    mask1 = {11'h7FF, 18'h0};
    fid[0] = 29'h1234567;
    fid[1] = {11'h123, 2'b11, 8'hAA, 8'h55};
    fid[2] = {11'h456, 18'h0};
    fid[3] = 29'h0ABCDEF;
    fid[4] = {11'h456, 18'h3FFFF};
    fid[5] = 29'h1FFFFFFF;
    fext   = 6'b101001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_match();
    t_ext_miss();
    t_std_data();
    t_buf1_prio();
    t_rollover();
    t_rxall();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule